// File: doc/BRIEF.md
# Processor Mode Controller and Address Region Decoder

This block sits between the CPU core of a small 8-bit microcontroller and its memories and port pads. It holds a mode register at address 0x003B that the CPU writes and reads over a simple register bus. The register selects one of three operating modes: single-chip, memory expansion and microprocessor. A strap input sets the mode when reset is released. Software may change it later, but only while the strap is low.

For every CPU address the block produces a one-hot region select: special-function registers, internal RAM, internal ROM, external bus, or nothing. In single-chip mode the four 8-bit ports pass the general I/O latches straight to the pads. In the two expansion modes the ports take on new roles. Port 0 carries the low address byte and port 1 the high address byte. Port 2 becomes the data bus. Port 3 carries the bus control strobes and status lines.

The mode is held as a three-state machine with the states ST_SINGLE, ST_EXPAND and ST_MICRO. Reset enters ST_SINGLE when the strap is low and ST_MICRO when it is high. While the strap is low, a register write with mode bits 00, 01 or 10 moves from any state to ST_SINGLE, ST_EXPAND or ST_MICRO. Any other write keeps the current state.

Top module: `mcu_mode_decoder`

## Requirements
- R1: Reset enters mode 00 (single-chip) when `strap` is low and mode 10 (microprocessor) when `strap` is high. The stack page bit resets to 0.
- R2: A read at address 0x003B returns {5'b0, stack_page, mode[1:0]}. Bits 7:3 always read 0.
- R3: While `strap` is low, a write to 0x003B with bits 1:0 equal to 00, 01 or 10 sets `cur_mode` to that value from the next clock. `cur_mode` never equals 11.
- R4: A write of 11 to the mode bits leaves the mode unchanged.
- R5: While `strap` is high, mode-bit writes are ignored and the mode stays 10.
- R6: Bit 2 of a write to 0x003B sets the stack page bit (0 = page 0, 1 = page 1) in every mode. `stack_page` shows its value.
- R7: `region_sel` is one-hot or zero, with bit 0 = SFR, bit 1 = RAM, bit 2 = ROM and bit 3 = external. Addresses 0x0000–0x003F select SFR and 0x0040–0x043F select RAM in every mode.
- R8: In single-chip mode, addresses at or above `ROM_BASE` select ROM. All other addresses outside SFR and RAM select nothing.
- R9: In memory expansion mode, addresses at or above `ROM_BASE` select ROM, so ROM has priority over external memory. Other addresses outside SFR and RAM select external.
- R10: In microprocessor mode, ROM is never selected. Every address outside SFR and RAM selects external.
- R11: In the expansion modes:
  - The read strobe (port 3 bit 7) and the write strobe (port 3 bit 6) are active low. Each is asserted only for a `cpu_rd` or `cpu_wr` access that decodes as external.
  - Port 2 drives `cpu_wdata` with all output enables high only while the write strobe is low.
  - An external read returns `pad2_in` on `cpu_rdata`.
- R12: In the expansion modes:
  - Port 0 outputs address bits 7:0 and port 1 outputs address bits 15:8, both fully enabled.
  - Port 3 outputs carry: bits 1:0 from the I/O latch, bit 3 the reset output, bit 4 `cpu_phi`, bit 5 `cpu_sync`, bit 6 the write strobe, bit 7 the read strobe.
  - Port 3 output enable is 0xFB, and bit 2 is the wait input shown on `bus_wait`.
- R13: In the expansion modes, `gp3_rdata` returns 0 in bits 1:0 and the pad inputs elsewhere. In single-chip mode every port passes its I/O latch and enable unchanged, `gp3_rdata` equals `pad3_in`, and `bus_wait` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 1 | Boot mode strap: low = single-chip, high = microprocessor |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Mode register or external read data |
| cur_mode | output | 2 | Current mode (00, 01, 10) |
| stack_page | output | 1 | Stack page select |
| region_sel | output | 4 | One-hot region select {ext, rom, ram, sfr} |
| cpu_phi | input | 1 | Clock to bring out on port 3 |
| cpu_sync | input | 1 | Opcode-fetch sync from the core |
| bus_wait | output | 1 | Wait input from port 3 bit 2 |
| gp0_out | input | 8 | Port 0 I/O latch |
| gp0_oe | input | 8 | Port 0 I/O direction |
| gp1_out | input | 8 | Port 1 I/O latch |
| gp1_oe | input | 8 | Port 1 I/O direction |
| gp2_out | input | 8 | Port 2 I/O latch |
| gp2_oe | input | 8 | Port 2 I/O direction |
| gp3_out | input | 8 | Port 3 I/O latch |
| gp3_oe | input | 8 | Port 3 I/O direction |
| gp3_rdata | output | 8 | Port 3 value seen by the CPU |
| pad0_out | output | 8 | Port 0 pad drive |
| pad0_oe | output | 8 | Port 0 pad enable |
| pad1_out | output | 8 | Port 1 pad drive |
| pad1_oe | output | 8 | Port 1 pad enable |
| pad2_out | output | 8 | Port 2 pad drive |
| pad2_oe | output | 8 | Port 2 pad enable |
| pad2_in | input | 8 | Port 2 pad input |
| pad3_out | output | 8 | Port 3 pad drive |
| pad3_oe | output | 8 | Port 3 pad enable |
| pad3_in | input | 8 | Port 3 pad input |

## Verification
The decode is swept in each of the three modes with a read at every 37th address plus the edges 0x003F/0x0040, 0x043F/0x0440, `ROM_BASE`-1/`ROM_BASE` and 0xFFFF. The edge addresses separate off-by-one errors at each region boundary. Running the same sweep under each mode separates the three ROM priority rules.

Writes of every code to the mode bits, under both strap levels, separate the accepted codes from the ignored ones. Writes to external and internal addresses separate correct strobe and data-bus enable gating from strobes that leak onto internal accesses. Distinct patterns on the I/O latches and pads separate pass-through in single-chip mode from the bus roles in the expansion modes.

// File: rtl/mcu_mode_pkg.sv
package mcu_mode_pkg;
    typedef enum logic [1:0] {
        ST_SINGLE = 2'b00,
        ST_EXPAND = 2'b01,
        ST_MICRO  = 2'b10
    } mode_state_t;

    localparam int RGN_SFR = 0;
    localparam int RGN_RAM = 1;
    localparam int RGN_ROM = 2;
    localparam int RGN_EXT = 3;
    localparam int RGN_N   = 4;

    // port 3 pin roles while an external bus is active
    localparam int P3_WAIT = 2;
    localparam int P3_RST  = 3;
    localparam int P3_PHI  = 4;
    localparam int P3_SYNC = 5;
    localparam int P3_WRN  = 6;
    localparam int P3_RDN  = 7;
endpackage

// File: rtl/mode_fsm.sv
module mode_fsm
    import mcu_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap,
    input  logic        reg_we,
    input  logic [2:0]  reg_wbits,
    output mode_state_t state,
    output logic        stk_pg
);
    mode_state_t nxt;
    logic        sw_ok;

    assign sw_ok = reg_we && !strap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= strap ? ST_MICRO : ST_SINGLE;
            stk_pg <= 1'b0;
        end else begin
            state <= nxt;
            if (reg_we) stk_pg <= reg_wbits[2];
        end
    end

    // transitions: a software write picks the target, code 11 keeps state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SINGLE, ST_EXPAND, ST_MICRO: begin
                if (sw_ok) begin
                    case (reg_wbits[1:0])
                        2'b00:   nxt = ST_SINGLE;
                        2'b01:   nxt = ST_EXPAND;
                        2'b10:   nxt = ST_MICRO;
                        default: nxt = state;
                    endcase
                end
            end
            default: nxt = ST_SINGLE;
        endcase
    end
endmodule

// File: rtl/addr_region.sv
module addr_region
    import mcu_mode_pkg::*;
#(
    parameter int              AW       = 16,
    parameter logic [AW-1:0]   SFR_LAST = 16'h003F,
    parameter logic [AW-1:0]   RAM_LAST = 16'h043F,
    parameter logic [AW-1:0]   ROM_BASE = 16'hC000
) (
    input  logic [AW-1:0]    addr,
    input  mode_state_t      mode,
    output logic [RGN_N-1:0] rgn
);
    logic in_sfr, in_ram, in_romspan;

    assign in_sfr     = (addr <= SFR_LAST);
    assign in_ram     = !in_sfr && (addr <= RAM_LAST);
    assign in_romspan = !in_sfr && !in_ram && (addr >= ROM_BASE);

    always_comb begin
        rgn = '0;
        if (in_sfr)      rgn[RGN_SFR] = 1'b1;
        else if (in_ram) rgn[RGN_RAM] = 1'b1;
        else begin
            unique case (mode)
                ST_SINGLE: rgn[RGN_ROM] = in_romspan;
                ST_EXPAND: begin
                    rgn[RGN_ROM] = in_romspan;
                    rgn[RGN_EXT] = !in_romspan;
                end
                ST_MICRO:  rgn[RGN_EXT] = 1'b1;
                default:   rgn = '0;
            endcase
        end
    end
endmodule

// File: rtl/port_mux.sv
module port_mux
    import mcu_mode_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  mode_state_t      mode,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             rd,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    input  logic [RGN_N-1:0] rgn,
    input  logic             phi,
    input  logic             sync,
    input  logic [DW-1:0]    g0_o, g0_e, g1_o, g1_e, g2_o, g2_e, g3_o, g3_e,
    input  logic [DW-1:0]    p3_in,
    output logic [DW-1:0]    p0_o, p0_e, p1_o, p1_e, p2_o, p2_e, p3_o, p3_e,
    output logic [DW-1:0]    g3_rd,
    output logic             wait_o
);
    logic ext_rd, ext_wr;

    assign ext_rd = rd && rgn[RGN_EXT];
    assign ext_wr = wr && rgn[RGN_EXT];

    always_comb begin
        p0_o = g0_o; p0_e = g0_e;
        p1_o = g1_o; p1_e = g1_e;
        p2_o = g2_o; p2_e = g2_e;
        p3_o = g3_o; p3_e = g3_e;
        g3_rd  = p3_in;
        wait_o = 1'b0;
        unique case (mode)
            ST_SINGLE: ;
            ST_EXPAND, ST_MICRO: begin
                p0_o = addr[7:0];
                p0_e = '1;
                p1_o = addr[AW-1:8];
                p1_e = '1;
                p2_o = wdata;
                p2_e = {DW{ext_wr}};
                p3_o          = '0;
                p3_o[1:0]     = g3_o[1:0];
                p3_o[P3_RST]  = !rst_n;
                p3_o[P3_PHI]  = phi;
                p3_o[P3_SYNC] = sync;
                p3_o[P3_WRN]  = !ext_wr;
                p3_o[P3_RDN]  = !ext_rd;
                p3_e          = '1;
                p3_e[P3_WAIT] = 1'b0;
                g3_rd         = {p3_in[DW-1:2], 2'b00};
                wait_o        = p3_in[P3_WAIT];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mcu_mode_decoder.sv
module mcu_mode_decoder
    import mcu_mode_pkg::*;
#(
    parameter int              AW       = 16,
    parameter int              DW       = 8,
    parameter logic [AW-1:0]   MODE_REG = 16'h003B,
    parameter logic [AW-1:0]   ROM_BASE = 16'hC000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic [DW-1:0]    cpu_rdata,
    output logic [1:0]       cur_mode,
    output logic             stack_page,
    output logic [RGN_N-1:0] region_sel,
    input  logic             cpu_phi,
    input  logic             cpu_sync,
    output logic             bus_wait,
    input  logic [DW-1:0]    gp0_out,
    input  logic [DW-1:0]    gp0_oe,
    input  logic [DW-1:0]    gp1_out,
    input  logic [DW-1:0]    gp1_oe,
    input  logic [DW-1:0]    gp2_out,
    input  logic [DW-1:0]    gp2_oe,
    input  logic [DW-1:0]    gp3_out,
    input  logic [DW-1:0]    gp3_oe,
    output logic [DW-1:0]    gp3_rdata,
    output logic [DW-1:0]    pad0_out,
    output logic [DW-1:0]    pad0_oe,
    output logic [DW-1:0]    pad1_out,
    output logic [DW-1:0]    pad1_oe,
    output logic [DW-1:0]    pad2_out,
    output logic [DW-1:0]    pad2_oe,
    input  logic [DW-1:0]    pad2_in,
    output logic [DW-1:0]    pad3_out,
    output logic [DW-1:0]    pad3_oe,
    input  logic [DW-1:0]    pad3_in
);
    localparam logic [AW-1:0] SFR_LAST = 16'h003F;
    localparam logic [AW-1:0] RAM_LAST = 16'h043F;

    mode_state_t st;
    logic        hit_reg;

    assign hit_reg = (cpu_addr == MODE_REG);

    mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (strap),
        .reg_we    (cpu_wr && hit_reg),
        .reg_wbits (cpu_wdata[2:0]),
        .state     (st),
        .stk_pg    (stack_page)
    );

    addr_region #(
        .AW(AW), .SFR_LAST(SFR_LAST), .RAM_LAST(RAM_LAST), .ROM_BASE(ROM_BASE)
    ) u_dec (
        .addr (cpu_addr),
        .mode (st),
        .rgn  (region_sel)
    );

    port_mux #(.AW(AW), .DW(DW)) u_pins (
        .mode   (st),
        .rst_n  (rst_n),
        .addr   (cpu_addr),
        .rd     (cpu_rd),
        .wr     (cpu_wr),
        .wdata  (cpu_wdata),
        .rgn    (region_sel),
        .phi    (cpu_phi),
        .sync   (cpu_sync),
        .g0_o   (gp0_out), .g0_e (gp0_oe),
        .g1_o   (gp1_out), .g1_e (gp1_oe),
        .g2_o   (gp2_out), .g2_e (gp2_oe),
        .g3_o   (gp3_out), .g3_e (gp3_oe),
        .p3_in  (pad3_in),
        .p0_o   (pad0_out), .p0_e (pad0_oe),
        .p1_o   (pad1_out), .p1_e (pad1_oe),
        .p2_o   (pad2_out), .p2_e (pad2_oe),
        .p3_o   (pad3_out), .p3_e (pad3_oe),
        .g3_rd  (gp3_rdata),
        .wait_o (bus_wait)
    );

    assign cur_mode = st;

    // read path: mode register first, then external data
    always_comb begin
        cpu_rdata = '0;
        if (hit_reg)
            cpu_rdata = {{(DW-3){1'b0}}, stack_page, cur_mode};
        else if (region_sel[RGN_EXT])
            cpu_rdata = pad2_in;
    end
endmodule

// File: rtl/mode_dec_chk.sv
module mode_dec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        strap,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [7:0]  cpu_wdata,
    input logic [1:0]  cur_mode,
    input logic [3:0]  region_sel,
    input logic [7:0]  pad2_oe,
    input logic [7:0]  pad3_out
);
    // R3
    legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mode != 2'b11);

    // R4
    bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h003B && cpu_wdata[1:0] == 2'b11) |=> $stable(cur_mode));

    // R5
    strap_micro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap |-> cur_mode == 2'b10);

    // R7
    region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel));

    // R10
    micro_no_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'b10) |-> !region_sel[2]);

    // R11
    wr_strobe_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != 2'b00 && !pad3_out[6]) |-> (cpu_wr && region_sel[3]));

    // R11
    rd_strobe_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != 2'b00 && !pad3_out[7]) |-> (cpu_rd && region_sel[3]));

    // R11
    data_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != 2'b00 && pad2_oe != 8'h00) |-> !pad3_out[6]);
endmodule

bind mcu_mode_decoder mode_dec_chk u_chk (.*);

// File: tb/sim_mcu_mode_decoder.sv
module sim_mcu_mode_decoder;
    localparam int ROMB = 16'hC000;

    logic        clk = 0, rst_n = 0, strap = 0;
    logic [15:0] cpu_addr = 0;
    logic        cpu_rd = 0, cpu_wr = 0;
    logic [7:0]  cpu_wdata = 0, cpu_rdata;
    logic [1:0]  cur_mode;
    logic        stack_page, bus_wait;
    logic [3:0]  region_sel;
    logic        cpu_phi = 0, cpu_sync = 0;
    logic [7:0]  gp0_out = 8'h11, gp0_oe = 8'h21, gp1_out = 8'h32, gp1_oe = 8'h43;
    logic [7:0]  gp2_out = 8'h54, gp2_oe = 8'h65, gp3_out = 8'h76, gp3_oe = 8'h87;
    logic [7:0]  gp3_rdata, pad0_out, pad0_oe, pad1_out, pad1_oe;
    logic [7:0]  pad2_out, pad2_oe, pad3_out, pad3_oe;
    logic [7:0]  pad2_in = 8'hA5, pad3_in = 8'hFF;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    mcu_mode_decoder u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_rgn(input int m, input int a);
        if (a <= 16'h003F) return 4'b0001;
        if (a <= 16'h043F) return 4'b0010;
        if (a >= ROMB && m != 2) return 4'b0100;
        if (m != 0) return 4'b1000;
        return 4'b0000;
    endfunction

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 0; strap = s;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] d);
        @(negedge clk);
        cpu_addr = 16'h003B; cpu_wdata = d; cpu_wr = 1;
        @(negedge clk);
        cpu_wr = 0;
    endtask

    task automatic probe(input int m, input int a);
        logic [3:0] e;
        cpu_addr = a[15:0]; cpu_rd = 1;
        #1;
        e = exp_rgn(m, a);
        if (m == 0)      chk("R8 region", region_sel, e);
        else if (m == 1) chk("R9 region", region_sel, e);
        else             chk("R10 region", region_sel, e);
        if (a <= 16'h043F) chk("R7 region", region_sel, e);
        if (m != 0) begin
            chk("R11 rd strobe", pad3_out[7], e[3] ? 1'b0 : 1'b1);
            if (e[3]) chk("R11 ext rdata", cpu_rdata, pad2_in);
            chk("R12 p0/p1 addr", {pad1_out, pad0_out}, a[15:0]);
        end else begin
            chk("R13 p0 passthru", pad0_out, gp0_out);
        end
        cpu_rd = 0;
        #1;
    endtask

    task automatic sweep(input int m);
        int edges[8] = '{0, 16'h3F, 16'h40, 16'h43F, 16'h440, ROMB-1, ROMB, 16'hFFFF};
        for (int a = 0; a < 65536; a += 37) probe(m, a);
        foreach (edges[i]) probe(m, edges[i]);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 strap low
        do_reset(0);
        chk("R1 mode", cur_mode, 2'b00);
        chk("R1 stack", stack_page, 1'b0);
        cpu_addr = 16'h003B; #1;
        chk("R2 readback", cpu_rdata, 8'h00);
        chk("R13 gp3 read", gp3_rdata, 8'hFF);
        chk("R13 wait", bus_wait, 1'b0);
        chk("R13 p2/p3", {pad2_out, pad2_oe, pad3_out, pad3_oe}, {gp2_out, gp2_oe, gp3_out, gp3_oe});
        chk("R13 p1", {pad1_out, pad1_oe, pad0_oe}, {gp1_out, gp1_oe, gp0_oe});
        sweep(0);

        // R3 enter expansion mode, R6 stack page
        reg_write(8'hFD);
        chk("R3 to expand", cur_mode, 2'b01);
        chk("R6 stack set", stack_page, 1'b1);
        cpu_addr = 16'h003B; #1;
        chk("R2 readback", cpu_rdata, 8'h05);
        reg_write(8'h03);
        chk("R4 code11 kept", cur_mode, 2'b01);
        chk("R6 stack clr", stack_page, 1'b0);
        sweep(1);

        // R11 external write strobe and data bus
        @(negedge clk);
        cpu_addr = 16'h2000; cpu_wdata = 8'h9C; cpu_wr = 1; #1;
        chk("R11 wr strobe", pad3_out[6], 1'b0);
        chk("R11 p2 oe", pad2_oe, 8'hFF);
        chk("R11 p2 data", pad2_out, 8'h9C);
        chk("R11 rd idle", pad3_out[7], 1'b1);
        cpu_addr = 16'h0100; #1;
        chk("R11 internal wr", pad3_out[6], 1'b1);
        chk("R11 internal oe", pad2_oe, 8'h00);
        cpu_addr = 16'hD000; #1;
        chk("R11 rom wr no strobe", pad3_out[6], 1'b1);
        cpu_wr = 0;
        // R12 port 3 roles
        cpu_phi = 1; cpu_sync = 0; pad3_in = 8'hFB; #1;
        chk("R12 p3 oe", pad3_oe, 8'hFB);
        chk("R12 p3 roles", pad3_out[5:0], {1'b0, 1'b1, 1'b0, 1'b0, gp3_out[1:0]});
        chk("R12 wait", bus_wait, 1'b0);
        chk("R13 gp3 read", gp3_rdata, 8'hF8);
        cpu_phi = 0; cpu_sync = 1; pad3_in = 8'h07; #1;
        chk("R12 p3 roles", pad3_out[5:4], 2'b10);
        chk("R12 wait", bus_wait, 1'b1);
        chk("R13 gp3 read", gp3_rdata, 8'h04);
        pad3_in = 8'hFF;

        // R3 to microprocessor
        reg_write(8'h02);
        chk("R3 to micro", cur_mode, 2'b10);
        sweep(2);
        reg_write(8'h00);
        chk("R3 to single", cur_mode, 2'b00);

        // R5 strap high
        do_reset(1);
        chk("R1 strap high", cur_mode, 2'b10);
        chk("R1 stack", stack_page, 1'b0);
        reg_write(8'h04);
        chk("R5 write ignored", cur_mode, 2'b10);
        chk("R6 stack", stack_page, 1'b1);
        reg_write(8'h01);
        chk("R5 write ignored", cur_mode, 2'b10);
        cpu_addr = 16'h003B; #1;
        chk("R2 readback", cpu_rdata, 8'h02);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule